// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks one integer-mode PLL through a safe change of divider settings. A requester supplies a feedback divider, a reference divider and two post dividers, then pulses a start strobe. The sequencer first decides whether the request yields a legal oscillator and output frequency from a 24 MHz reference. A request that fails is refused with a one-cycle error pulse, and the PLL controls stay exactly as they were.

An accepted request is carried out as a fixed series of register steps. The mode control is placed in slow (bypass) mode. Integer mode is then forced with the sigma-delta modulator off. Next the divider fields are written. The sequencer polls the lock bit of the PLL status word and returns the mode control to normal only after lock has been seen. A programmable timeout cuts the wait short, raises the error pulse and leaves the PLL in slow mode. Busy covers the whole series, and done pulses once at the end of a successful change.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, mode_o is slow (2'b00), int_mode_o is 0, fb_reg_o and post_reg_o are 0, and busy_o, done_o and err_o are 0.
- R2: A request is accepted only if the oscillator frequency 24·fbdiv/refdiv (MHz, exact) is within 800 to 3200 inclusive. A refused request gives a one-cycle err_o pulse in the cycle after start_i, and fb_reg_o, post_reg_o and mode_o keep their values.
- R3: A request is refused if refdiv, postdiv1 or postdiv2 is zero, or if the output frequency (oscillator / postdiv1 / postdiv2) falls outside 16 to 3200 MHz inclusive.
- R4: A request is refused if fbdiv is below 16 or above 3200, even when its oscillator frequency is legal.
- R5: For an accepted request, mode_o is set to slow first, int_mode_o is set to 1 one cycle later, and the divider registers are written one cycle after that. fb_reg_o and post_reg_o never change unless mode_o is slow and int_mode_o is 1.
- R6: fb_reg_o carries fbdiv. post_reg_o carries refdiv in bits [5:0], postdiv1 in bits [10:8] and postdiv2 in bits [14:12], and holds 0 in all other bits.
- R7: Lock is read from bit 31 of lock_stat_i, and the other bits of that word are ignored. mode_o turns normal (2'b01) only in the cycle after a cycle in which the sequencer was waiting and bit 31 was 1.
- R8: done_o is high for exactly one cycle, one cycle after mode_o has become normal. busy_o falls in that same cycle.
- R9: If lock is not seen within lock_limit_i+1 waiting cycles, err_o pulses for one cycle, busy_o falls, and mode_o stays slow while the new divider values remain programmed. If lock and the timeout occur in the same cycle, lock wins.
- R10: A start_i pulse that arrives while busy_o is high has no effect on the divider registers or on the outcome.
- R11: err_o is a single-cycle pulse and is never high in the same cycle as done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| fbdiv_i | input | 12 | Requested feedback divider |
| refdiv_i | input | 6 | Requested reference divider |
| postdiv1_i | input | 3 | Requested first post divider |
| postdiv2_i | input | 3 | Requested second post divider |
| lock_limit_i | input | 16 | Lock wait limit in cycles (limit+1 cycles are waited) |
| lock_stat_i | input | 32 | PLL status word; bit 31 is lock |
| fb_reg_o | output | 12 | Feedback divider register to the PLL |
| post_reg_o | output | 16 | Reference and post divider register to the PLL |
| mode_o | output | 2 | PLL mode control: 00 slow, 01 normal |
| int_mode_o | output | 1 | 1 selects integer mode with the modulator disabled |
| busy_o | output | 1 | High while a change is in progress |
| done_o | output | 1 | One-cycle pulse when a change completes |
| err_o | output | 1 | One-cycle pulse on a refused request or a lock timeout |

## Verification
Two cases are hard to reach from the ports. In the first, the lock wait expires while the PLL is still in slow mode with new dividers in place. In the second, a start arrives in the middle of a change. The bench models the PLL as a lock bit that rises a chosen number of cycles after the block enters slow integer mode. A very large delay against a small or zero limit forces the timeout path, and a later short delay confirms that the block recovers. For the second case, a legal but different request is pulsed while the first one waits for lock, and the bench then watches the outputs long enough to show that no second outcome and no register change follow.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOW,
        ST_INTM,
        ST_PROG,
        ST_WAIT,
        ST_NORM
    } seq_st_e;

    localparam logic [1:0] MODE_SLOW = 2'b00;
    localparam logic [1:0] MODE_NORM = 2'b01;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
    parameter int FB_W    = 12,
    parameter int REF_W   = 6,
    parameter int PD_W    = 3,
    parameter int REF_MHZ = 24,
    parameter int VCO_MIN = 800,
    parameter int VCO_MAX = 3200,
    parameter int OUT_MIN = 16,
    parameter int OUT_MAX = 3200,
    parameter int FB_MIN  = 16,
    parameter int FB_MAX  = 3200
) (
    input  logic [FB_W-1:0]  fb_i,
    input  logic [REF_W-1:0] rd_i,
    input  logic [PD_W-1:0]  pd1_i,
    input  logic [PD_W-1:0]  pd2_i,
    output logic             ok_o
);
    // Division-free compare: frequencies are scaled by the divisors instead.
    localparam int AW = FB_W + REF_W + 2 * PD_W + 16;

    logic [AW-1:0] prod, rd_x, div_all;
    logic          vco_ok, out_ok, fb_ok, nz_ok;

    always_comb begin
        prod    = AW'(fb_i) * AW'(REF_MHZ);
        rd_x    = AW'(rd_i);
        div_all = rd_x * AW'(pd1_i) * AW'(pd2_i);
        vco_ok  = (prod >= AW'(VCO_MIN) * rd_x) && (prod <= AW'(VCO_MAX) * rd_x);
        out_ok  = (prod >= AW'(OUT_MIN) * div_all) && (prod <= AW'(OUT_MAX) * div_all);
        fb_ok   = (fb_i >= FB_W'(FB_MIN)) && (fb_i <= FB_W'(FB_MAX));
        nz_ok   = (rd_i != '0) && (pd1_i != '0) && (pd2_i != '0);
        ok_o    = nz_ok && fb_ok && vco_ok && out_ok;
    end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             exp_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && cnt_q != limit_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign exp_o = (cnt_q == limit_i);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int FB_W     = 12,
    parameter int REF_W    = 6,
    parameter int PD_W     = 3,
    parameter int POST_W   = 16,
    parameter int RD_LSB   = 0,
    parameter int PD1_LSB  = 8,
    parameter int PD2_LSB  = 12,
    parameter int STAT_W   = 32,
    parameter int LOCK_BIT = 31,
    parameter int TMO_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FB_W-1:0]   fbdiv_i,
    input  logic [REF_W-1:0]  refdiv_i,
    input  logic [PD_W-1:0]   postdiv1_i,
    input  logic [PD_W-1:0]   postdiv2_i,
    input  logic [TMO_W-1:0]  lock_limit_i,
    input  logic [STAT_W-1:0] lock_stat_i,
    output logic [FB_W-1:0]   fb_reg_o,
    output logic [POST_W-1:0] post_reg_o,
    output logic [1:0]        mode_o,
    output logic              int_mode_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        mode;
        logic              int_mode;
        logic [FB_W-1:0]   fb;
        logic [FB_W-1:0]   fb_req;
        logic [POST_W-1:0] post;
        logic [POST_W-1:0] post_req;
        logic              busy;
        logic              done;
        logic              err;
    } regs_t;

    regs_t             r_d, r_q;
    logic              req_ok;
    logic              tmr_clr, tmr_en, tmr_exp;
    logic [POST_W-1:0] post_new;

    pll_req_check #(
        .FB_W (FB_W),
        .REF_W(REF_W),
        .PD_W (PD_W)
    ) u_check (
        .fb_i (fbdiv_i),
        .rd_i (refdiv_i),
        .pd1_i(postdiv1_i),
        .pd2_i(postdiv2_i),
        .ok_o (req_ok)
    );

    pll_lock_timer #(
        .CNT_W(TMO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .en_i   (tmr_en),
        .limit_i(lock_limit_i),
        .exp_o  (tmr_exp)
    );

    // Field placement that the PLL decodes.
    always_comb begin
        post_new                      = '0;
        post_new[RD_LSB  +: REF_W]    = refdiv_i;
        post_new[PD1_LSB +: PD_W]     = postdiv1_i;
        post_new[PD2_LSB +: PD_W]     = postdiv2_i;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        tmr_clr  = 1'b0;
        tmr_en   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (req_ok) begin
                        r_d.st       = ST_SLOW;
                        r_d.busy     = 1'b1;
                        r_d.fb_req   = fbdiv_i;
                        r_d.post_req = post_new;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_SLOW: begin
                r_d.mode = MODE_SLOW;
                r_d.st   = ST_INTM;
            end
            ST_INTM: begin
                r_d.int_mode = 1'b1;
                r_d.st       = ST_PROG;
            end
            ST_PROG: begin
                r_d.fb   = r_q.fb_req;
                r_d.post = r_q.post_req;
                tmr_clr  = 1'b1;
                r_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (lock_stat_i[LOCK_BIT]) begin
                    r_d.mode = MODE_NORM;
                    r_d.st   = ST_NORM;
                end else if (tmr_exp) begin
                    r_d.err  = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = ST_IDLE;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_NORM: begin
                r_d.done = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.mode     <= MODE_SLOW;
        end else begin
            r_q <= r_d;
        end
    end

    assign fb_reg_o   = r_q.fb;
    assign post_reg_o = r_q.post;
    assign mode_o     = r_q.mode;
    assign int_mode_o = r_q.int_mode;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

endmodule

// File: rtl/pll_reprog_seq_sva.sv
module pll_reprog_seq_sva
    import pll_seq_pkg::*;
#(
    parameter int FB_W     = 12,
    parameter int POST_W   = 16,
    parameter int STAT_W   = 32,
    parameter int LOCK_BIT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] lock_stat_i,
    input logic [FB_W-1:0]   fb_reg_o,
    input logic [POST_W-1:0] post_reg_o,
    input logic [1:0]        mode_o,
    input logic              int_mode_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);

    a_r7_norm_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_NORM && $past(mode_o) != MODE_NORM) |-> $past(lock_stat_i[LOCK_BIT]));

    a_r5_prog_in_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fb_reg_o) || !$stable(post_reg_o)) |-> (mode_o == MODE_SLOW && int_mode_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_normal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mode_o == MODE_NORM && !busy_o));

    a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));

    a_r2_reject_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(busy_o)) |-> ($stable(fb_reg_o) && $stable(post_reg_o) && $stable(mode_o)));

endmodule

bind pll_reprog_seq pll_reprog_seq_sva #(
    .FB_W    (FB_W),
    .POST_W  (POST_W),
    .STAT_W  (STAT_W),
    .LOCK_BIT(LOCK_BIT)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_stat_i(lock_stat_i),
    .fb_reg_o   (fb_reg_o),
    .post_reg_o (post_reg_o),
    .mode_o     (mode_o),
    .int_mode_o (int_mode_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] fbdiv_i = '0;
    logic [5:0]  refdiv_i = '0;
    logic [2:0]  postdiv1_i = '0;
    logic [2:0]  postdiv2_i = '0;
    logic [15:0] lock_limit_i = '0;
    logic [31:0] lock_stat_i;
    logic [11:0] fb_reg_o;
    logic [15:0] post_reg_o;
    logic [1:0]  mode_o;
    logic        int_mode_o, busy_o, done_o, err_o;

    int nchk = 0;
    int nfail = 0;
    int lock_dly = 0;
    int lock_cnt = 0;

    typedef struct {
        bit          is_err;
        logic [11:0] fb;
        logic [15:0] post;
        logic [1:0]  mode;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [11:0] m_fb = '0;
    logic [15:0] m_post = '0;
    logic [1:0]  m_mode = 2'b00;

    always #10 clk = ~clk;

    pll_reprog_seq u_pll_reprog_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fbdiv_i     (fbdiv_i),
        .refdiv_i    (refdiv_i),
        .postdiv1_i  (postdiv1_i),
        .postdiv2_i  (postdiv2_i),
        .lock_limit_i(lock_limit_i),
        .lock_stat_i (lock_stat_i),
        .fb_reg_o    (fb_reg_o),
        .post_reg_o  (post_reg_o),
        .mode_o      (mode_o),
        .int_mode_o  (int_mode_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    // PLL model: lock rises a set number of cycles after slow integer mode is entered.
    always @(posedge clk) begin
        if (busy_o && int_mode_o && mode_o == 2'b00) lock_cnt <= lock_cnt + 1;
        else                                           lock_cnt <= 0;
    end
    assign lock_stat_i = {(busy_o && int_mode_o && mode_o == 2'b00 && lock_cnt >= lock_dly),
                          31'h2A5A_5A5A};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard.
    logic [11:0] prev_fb = '0;
    logic [15:0] prev_post = '0;
    logic        prev_err = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fb_reg_o != prev_fb || post_reg_o != prev_post)
                chk(mode_o == 2'b00 && int_mode_o, "R5", "write outside slow integer mode",
                    {mode_o, int_mode_o}, 3'b001);
            if (err_o && prev_err)
                chk(1'b0, "R11", "err_o longer than one cycle", 1, 0);
            if (done_o || err_o) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected outcome", {done_o, err_o}, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(err_o == e.is_err && done_o == !e.is_err, e.tag, "outcome err/done",
                        {err_o, done_o}, {e.is_err, !e.is_err});
                    chk(fb_reg_o == e.fb, e.tag, "fb_reg_o", fb_reg_o, e.fb);
                    chk(post_reg_o == e.post, e.tag, "post_reg_o", post_reg_o, e.post);
                    chk(mode_o == e.mode, e.tag, "mode_o", mode_o, e.mode);
                    chk(!busy_o, e.tag, "busy_o at outcome", busy_o, 0);
                end
            end
        end
        prev_fb   = fb_reg_o;
        prev_post = post_reg_o;
        prev_err  = err_o;
    end

    function automatic bit legal(input int fb, input int rd, input int p1, input int p2);
        longint f24 = longint'(fb) * 24;
        if (rd == 0 || p1 == 0 || p2 == 0) return 0;
        if (fb < 16 || fb > 3200) return 0;
        if (f24 < 800 * rd || f24 > 3200 * rd) return 0;
        if (f24 < longint'(16) * rd * p1 * p2 || f24 > longint'(3200) * rd * p1 * p2) return 0;
        return 1;
    endfunction

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input int fb, input int rd, input int p1, input int p2);
        @(negedge clk);
        fbdiv_i    = 12'(fb);
        refdiv_i   = 6'(rd);
        postdiv1_i = 3'(p1);
        postdiv2_i = 3'(p2);
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
    endtask

    // Driver: predicts the outcome from the requirements and queues it.
    task automatic run_req(input int fb, input int rd, input int p1, input int p2,
                           input int dly, input int lim, input bit locks, input string tag);
        exp_t e;
        e.tag = tag;
        lock_dly     = dly;
        lock_limit_i = 16'(lim);
        if (!legal(fb, rd, p1, p2)) begin
            e.is_err = 1'b1;
        end else begin
            m_fb   = 12'(fb);
            m_post = 16'(rd) | (16'(p1) << 8) | (16'(p2) << 12);
            m_mode = locks ? 2'b01 : 2'b00;
            e.is_err = !locks;
        end
        e.fb   = m_fb;
        e.post = m_post;
        e.mode = m_mode;
        expq.push_back(e);
        launch(fb, rd, p1, p2);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mode_o == 2'b00, "R1", "mode_o", mode_o, 0);
        chk(int_mode_o == 1'b0, "R1", "int_mode_o", int_mode_o, 0);
        chk(fb_reg_o == '0 && post_reg_o == '0, "R1", "divider regs", {fb_reg_o, post_reg_o}, 0);
        chk({busy_o, done_o, err_o} == 3'b000, "R1", "flags", {busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_req(100, 3, 1, 1, 3, 50, 1, "R2");        // oscillator exactly 800
        run_req(99, 3, 1, 1, 3, 50, 1, "R2");         // 792, refused, mode stays normal
        run_req(400, 3, 2, 2, 5, 50, 1, "R6");        // oscillator exactly 3200, R2 upper edge
        run_req(401, 3, 1, 1, 3, 50, 1, "R2");        // above 3200, refused
        run_req(3201, 25, 1, 1, 3, 50, 1, "R4");      // legal oscillator, fbdiv too large
        run_req(3200, 25, 1, 2, 3, 50, 1, "R4");      // fbdiv at upper edge, accepted
        run_req(100, 2, 0, 1, 3, 50, 1, "R3");        // zero post divider
        run_req(100, 0, 1, 1, 3, 50, 1, "R3");        // zero reference divider
        run_req(128, 3, 7, 7, 2, 50, 1, "R3");        // deepest post division, accepted
        run_req(150, 3, 2, 3, 1000000, 20, 0, "R9");  // timeout, stays slow, R7
        run_req(160, 3, 1, 1, 1000000, 0, 0, "R9");   // zero limit timeout
        run_req(200, 4, 3, 1, 4, 30, 1, "R7");        // recovers and locks

        // R10: a start while busy is ignored.
        begin
            exp_t e;
            lock_dly     = 20;
            lock_limit_i = 16'd200;
            m_fb   = 12'd128;
            m_post = 16'd3 | (16'd2 << 8) | (16'd1 << 12);
            m_mode = 2'b01;
            e.is_err = 1'b0; e.fb = m_fb; e.post = m_post; e.mode = m_mode; e.tag = "R10";
            expq.push_back(e);
            launch(128, 3, 2, 1);
            repeat (6) @(negedge clk);
            launch(200, 2, 1, 1);
            drain();
            repeat (40) @(negedge clk);
            chk(fb_reg_o == 12'd128, "R10", "fb_reg_o after ignored start", fb_reg_o, 128);
            chk(!busy_o, "R10", "busy_o after ignored start", busy_o, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule